// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire serial memory. It holds a byte array of `2**ADDR_W` entries (4096 at the default width) and follows the clock and data lines of the bus. It recognises start and stop conditions and answers only to a select byte that carries the fixed prefix `1010` followed by the three strap inputs. Through that select byte a controller can write single bytes, perform random reads, sequential reads and current-address reads. The clock and data lines are brought into the system clock domain with two-flop synchronizers. Every bus event is derived from the edges of those synchronized copies.

SDA is split into two signals, an input `sda_i` and an open-drain pull-down enable `sda_oe`. The block acknowledges a byte by holding SDA low for the whole of the ninth clock. After a committed write it runs an internal write interval of `WR_CYCLES` system clocks. For that interval it ignores its own select code, so a controller can poll it until it answers again. When the write-protect input is high, the block still acknowledges write traffic but never changes the array.

Top module: `serial_eeprom_target`

## Requirements
- R1: After reset, `sda_oe` is low and the block stays silent until a start condition is followed by a matching select byte. Once reset is released it acknowledges that byte at once, with no write interval pending.
- R2: A select byte is acknowledged only when its bits 7..4 are `1010` and its bits 3..1 equal `strap_i[2:0]`. Bit 0 is 1 for read and 0 for write. A byte that does not match is not acknowledged, and nothing else is acknowledged until the next start condition.
- R3: A write transfer sends the select byte with bit 0 = 0, then an address high byte, an address low byte and one data byte, each acknowledged, and ends with a stop. That stop stores the data byte at the address taken from the low `ADDR_W` bits of {high, low}. Address bits above `ADDR_W` are ignored.
- R4: A random read is a write select, the two address bytes, a repeated start and a read select. The first byte returned is the one stored at that address, sent MSB first.
- R5: During a read, a low acknowledge from the controller makes the block send the byte at the next address. The address wraps from the last entry to entry 0. A high acknowledge ends the transfer.
- R6: A read select with no preceding address returns the byte that follows the last byte read or written.
- R7: When `wp_i` is high at the stop that ends a write, the array is left unchanged and no write interval starts. The write's select, address and data bytes are still acknowledged.
- R8: A committed write starts a write interval of `WR_CYCLES` clocks. During that interval a matching select byte is not acknowledged. After it ends, the select byte is acknowledged again.
- R9: A start condition at any point, even in the middle of a byte, restarts reception of a select byte. A stop condition returns the block to idle with SDA released.
- R10: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | Pull SDA low when 1, release when 0 |
| strap_i | input | 3 | Hard-wired select bits compared against select bits 3..1 |
| wp_i | input | 1 | Write protect for the whole array, active high |

## Verification
The bench builds the block with `ADDR_W = 6` and `WR_CYCLES = 200`. The 64-entry array can therefore be written and read back completely, and a sequential read crosses the wrap from entry 63 to entry 0 after a few bytes. The short write interval keeps busy polling at two or three select attempts per write, while the interval is still longer than one select byte on the bus, so the refused acknowledge can be observed. All eight strap combinations are swept against a fixed strap setting, and every address byte carries nonzero bits above the array width.

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target #(
  parameter int          ADDR_W     = 12,
  parameter int          WR_CYCLES  = 250000,
  parameter logic [3:0]  SEL_PREFIX = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BW    = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_AHI, S_ALO, S_WDAT, S_RDAT} st_t;

  logic [2:0] scl_p, sda_p;
  logic scl_s, scl_q, sda_s, sda_q;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  st_t st;
  logic st_sel, st_idle;
  logic [3:0] cnt;
  logic [7:0] sh, hi, rbyte, wbyte, rd_word;
  logic [ADDR_W-1:0] addr, waddr;
  logic mack, pull, pend, busy, sel_hit, mem_we;
  logic [BW-1:0] busy_cnt;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  assign scl_s     = scl_p[1];
  assign scl_q     = scl_p[2];
  assign sda_s     = sda_p[1];
  assign sda_q     = sda_p[2];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

  assign st_sel  = (st == S_SEL);
  assign st_idle = (st == S_IDLE);
  assign busy    = (busy_cnt != '0);
  assign sel_hit = (sh[7:4] == SEL_PREFIX) && (sh[3:1] == strap_i) && !busy;
  assign mem_we  = stop_evt & pend & ~wp_i;
  assign rd_word = mem[addr];
  assign sda_oe  = pull;

  always_ff @(posedge clk)
    if (mem_we) mem[waddr] <= wbyte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      busy_cnt <= '0;
    else if (mem_we) busy_cnt <= BW'(WR_CYCLES);
    else if (busy)   busy_cnt <= busy_cnt - BW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      sh    <= '0;
      hi    <= '0;
      addr  <= '0;
      rbyte <= '0;
      mack  <= 1'b1;
      pull  <= 1'b0;
      pend  <= 1'b0;
      wbyte <= '0;
      waddr <= '0;
    end else if (start_evt) begin
      st   <= S_SEL;
      cnt  <= '0;
      pull <= 1'b0;
      pend <= 1'b0;
    end else if (stop_evt) begin
      st   <= S_IDLE;
      cnt  <= '0;
      pull <= 1'b0;
      pend <= 1'b0;
    end else if (!st_idle) begin
      if (scl_rise) begin
        if (cnt < 4'd8) begin
          if (st != S_RDAT) sh <= {sh[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end else if (cnt == 4'd8) begin
          mack <= sda_s;
          cnt  <= 4'd9;
        end
      end else if (scl_fall) begin
        if (cnt == 4'd9) begin
          cnt  <= '0;
          pull <= 1'b0;
          if (st == S_RDAT) begin
            if (!mack) begin
              rbyte <= {rd_word[6:0], 1'b0};
              pull  <= ~rd_word[7];
              addr  <= addr + ADDR_W'(1);
            end else begin
              st <= S_IDLE;
            end
          end
        end else if (st == S_RDAT) begin
          if (cnt == 4'd8) begin
            pull <= 1'b0;
          end else if (cnt != 4'd0) begin
            pull  <= ~rbyte[7];
            rbyte <= {rbyte[6:0], 1'b0};
          end
        end else if (cnt == 4'd8) begin
          if (st_sel) begin
            if (sel_hit) begin
              pull <= 1'b1;
              st   <= sh[0] ? S_RDAT : S_AHI;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            case (st)
              S_AHI: begin
                hi   <= sh;
                pull <= 1'b1;
                st   <= S_ALO;
              end
              S_ALO: begin
                addr <= ADDR_W'({hi, sh});
                pull <= 1'b1;
                st   <= S_WDAT;
              end
              S_WDAT: if (!pend) begin
                pend  <= 1'b1;
                wbyte <= sh;
                waddr <= addr;
                addr  <= addr + ADDR_W'(1);
                pull  <= 1'b1;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/serial_eeprom_target_chk.sv
module serial_eeprom_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic busy,
  input logic wp_i,
  input logic mem_we,
  input logic start_evt,
  input logic stop_evt,
  input logic st_sel,
  input logic st_idle
);
  AST_SDA_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe)); // R10

  AST_NO_BUSY_WHEN_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp_i)); // R7

  AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> busy); // R8

  AST_NO_SELECT_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && $past(st_sel)) |-> !$past(busy)); // R8

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (st_idle && !sda_oe)); // R9

  AST_START_TO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> st_sel); // R9
endmodule

bind serial_eeprom_target serial_eeprom_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .busy(busy),
  .wp_i(wp_i), .mem_we(mem_we), .start_evt(start_evt), .stop_evt(stop_evt),
  .st_sel(st_sel), .st_idle(st_idle)
);

// File: tb/tb_serial_eeprom_target.sv
module tb_serial_eeprom_target;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int N = 1 << AW;
  localparam int WRC = 200;
  localparam int Q = 4;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic sda_oe;
  logic sda_line;
  int checks = 0, fails = 0;

  assign sda_line = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_eeprom_target #(.ADDR_W(AW), .WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_i(STRAP), .wp_i(wp)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 29 + 7);
  endfunction

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    q(); m_sda = b; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    q(); m_sda = 1'b1; q(); m_scl = 1'b1; q(); b = sda_line; q(); m_scl = 1'b0;
  endtask

  task automatic do_start();
    q(); m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0;
  endtask

  task automatic do_stop();
    q(); m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = !a;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(!give_ack);
  endtask

  task automatic select(input logic rd, output logic ack);
    do_start();
    send_byte({4'b1010, STRAP, rd}, ack);
  endtask

  task automatic poll_write_select();
    logic ack;
    for (int k = 0; k < 10; k++) begin
      select(1'b0, ack);
      if (ack) return;
      do_stop();
    end
    chk(1'b0, "R8 poll never acknowledged", 0, 1);
  endtask

  task automatic set_ptr(input int a, input logic [7:0] junk_hi, input logic [1:0] junk_lo);
    logic ack;
    poll_write_select();
    send_byte(junk_hi, ack);
    chk(ack, "R4 address high ack", int'(ack), 1);
    send_byte({junk_lo, 6'(a)}, ack);
    chk(ack, "R4 address low ack", int'(ack), 1);
  endtask

  task automatic write_one(input int a, input logic [7:0] d);
    logic ack;
    poll_write_select();
    send_byte(8'hA7, ack);
    chk(ack, "R3 address high ack", int'(ack), 1);
    send_byte({2'b11, 6'(a)}, ack);
    chk(ack, "R3 address low ack", int'(ack), 1);
    send_byte(d, ack);
    chk(ack, "R3 data ack", int'(ack), 1);
    do_stop();
  endtask

  task automatic read_at(input int a, output logic [7:0] d);
    logic ack;
    set_ptr(a, 8'h3C, 2'b01);
    select(1'b1, ack);
    chk(ack, "R4 read select ack", int'(ack), 1);
    recv_byte(d, 1'b0);
    do_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    logic ack, ack2;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: quiet after reset, answers at once
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", int'(sda_oe), 0);
    select(1'b0, ack);
    chk(ack, "R1 first select acknowledged", int'(ack), 1);
    do_stop();

    // R2: strap sweep and prefix check
    for (int s = 0; s < 8; s++) begin
      do_start();
      send_byte({4'b1010, 3'(s), 1'b0}, ack);
      chk(ack == (3'(s) == STRAP), "R2 strap compare", int'(ack), int'(3'(s) == STRAP));
      if (!ack) begin
        send_byte(8'h00, ack2);
        chk(!ack2, "R2 silent after mismatch", int'(ack2), 0);
      end
      do_stop();
    end
    do_start();
    send_byte({4'b1011, STRAP, 1'b0}, ack);
    chk(!ack, "R2 wrong prefix", int'(ack), 0);
    do_stop();

    // R3: fill the array, upper address bits nonzero
    for (int a = 0; a < N; a++) write_one(a, pat(a));

    // R3: sequential read-back of every entry
    set_ptr(0, 8'h91, 2'b10);
    select(1'b1, ack);
    chk(ack, "R3 read select ack", int'(ack), 1);
    for (int a = 0; a < N; a++) begin
      recv_byte(d, a != N - 1);
      chk(d == pat(a), "R3 stored byte", int'(d), int'(pat(a)));
    end
    do_stop();

    // R4: random reads
    for (int a = 3; a < N; a += 13) begin
      read_at(a, d);
      chk(d == pat(a), "R4 random read", int'(d), int'(pat(a)));
    end

    // R5: sequential read across the wrap
    set_ptr(N - 4, 8'h0F, 2'b11);
    select(1'b1, ack);
    for (int i = 0; i < 8; i++) begin
      recv_byte(d, i != 7);
      chk(d == pat((N - 4 + i) % N), "R5 sequential wrap", int'(d), int'(pat((N - 4 + i) % N)));
    end
    do_stop();

    // R6: current-address read continues at entry 4
    select(1'b1, ack);
    chk(ack, "R6 read select ack", int'(ack), 1);
    recv_byte(d, 1'b0);
    chk(d == pat(4), "R6 current address read", int'(d), int'(pat(4)));
    do_stop();

    // R9: start in the middle of a byte restarts select reception
    select(1'b0, ack);
    send_byte(8'h00, ack);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    do_start();
    send_byte({4'b1010, STRAP, 1'b1}, ack);
    chk(ack, "R9 select after mid-byte start", int'(ack), 1);
    recv_byte(d, 1'b0);
    chk(d == pat(5), "R9 pointer untouched by aborted bytes", int'(d), int'(pat(5)));
    do_stop();
    // R9: after stop, a byte without start is ignored
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    chk(!ack, "R9 no ack without start", int'(ack), 0);
    q(); m_sda = 1'b1; q(); m_scl = 1'b1; q();

    // R7: protected write is acknowledged but ignored, no busy interval
    wp = 1'b1;
    write_one(10, ~pat(10));
    select(1'b0, ack);
    chk(ack, "R7 no write interval when protected", int'(ack), 1);
    do_stop();
    wp = 1'b0;
    read_at(10, d);
    chk(d == pat(10), "R7 array unchanged", int'(d), int'(pat(10)));

    // R8: select refused during the write interval, accepted after
    write_one(20, 8'h5A);
    select(1'b0, ack);
    chk(!ack, "R8 select refused while busy", int'(ack), 0);
    do_stop();
    repeat (WRC + 20) @(negedge clk);
    select(1'b0, ack);
    chk(ack, "R8 select accepted after interval", int'(ack), 1);
    do_stop();
    read_at(20, d);
    chk(d == 8'h5A, "R8 rewritten byte", int'(d), 8'h5A);
    chk(sda_oe == 1'b0, "R9 released when idle", int'(sda_oe), 0);

    report();
  end
endmodule